// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Checker

This block checks the CRC-4 protection of a received E1 bit stream that an upstream synchronizer has already aligned to frames and multiframes. The synchronizer supplies one serial bit per accepted cycle, with a strobe that marks the bit as valid. It also marks the first bit of every frame and the first bit of every submultiframe. A submultiframe is eight frames long. The block computes the four-bit CRC over each submultiframe. It collects the four check bits that travel in the submultiframe after it and compares the two values.

Each submultiframe whose comparison fails gives a one-cycle error pulse and adds one to a saturating error counter. Software reads the counter through a read-and-clear strobe. The strobe copies the count into a holding register and restarts the count. An error detected in the same cycle as the strobe is not lost: it becomes the first count of the new period. Checking runs only while it is enabled, the CRC-4 multiframe format is selected and the synchronizer reports alignment. Whenever any of these three drops, the block forgets everything it has collected.

Top module: `e1_crc4_checker`

## Requirements
- R1: The computed value is the remainder of M(x)·x^4 divided by x^4 + x + 1. M(x) is every accepted bit of one submultiframe, first bit as the highest power, with the four check-bit positions counted as zero. Bit 3 of the value is the x^3 coefficient.
- R2: Check bits sit on the first bit of frames 0, 2, 4 and 6 of a submultiframe. Frames are counted from the submultiframe marker by the frame markers. The bit in frame 0 is compared with computed bit 3, and the bit in frame 6 with computed bit 0.
- R3: At the first bit of submultiframe n+2, the value computed over submultiframe n is compared with the check bits received in submultiframe n+1. A mismatch drives errPulse high for exactly the one cycle after that bit is accepted. errPulse is never high at any other time.
- R4: A comparison with one to four differing bits adds exactly one to errCount, and it does so in the same cycle that errPulse rises.
- R5: errCount is CNT_W bits wide (16 by default). It stops at all ones and never wraps.
- R6: While rdClr is high, rdValue takes the current errCount on the clock edge. errCount becomes 1 if a mismatch is detected in that same cycle and 0 otherwise.
- R7: A comparison happens only while enable, crcFormat and alignOk are all high. Otherwise errPulse stays low and errCount does not change, except through rdClr.
- R8: When checking becomes active, the first two submultiframe markers that follow produce no comparison. The first comparison is made at the third marker.
- R9: A cycle with bitValid low is ignored. This holds for its data bit and its markers, and leaves errCount and errPulse unchanged.
- R10: After reset, errCount, rdValue and errPulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Checking enabled |
| crcFormat | input | 1 | The multiframe format carries CRC-4 |
| alignOk | input | 1 | Upstream multiframe alignment is held |
| bitValid | input | 1 | bitData and the markers are valid in this cycle |
| bitData | input | 1 | Received serial bit |
| frameStart | input | 1 | This bit is the first bit of a frame |
| smfStart | input | 1 | This bit is the first bit of a submultiframe (also a frame start) |
| rdClr | input | 1 | Copy the count to rdValue and clear it |
| errCount | output | CNT_W | Saturating error count |
| rdValue | output | CNT_W | Count captured by the last rdClr |
| errPulse | output | 1 | One-cycle pulse for a failed submultiframe |

## Verification
The stream is built from random payload with correct check bits, and the check bits of each submultiframe come from a long-division model of the one before it. A clean run shows that the polynomial, the zeroed check positions and the bit order all agree. A single flipped check bit is compared with all four bits inverted, to show that one failing submultiframe counts once no matter how many bits differ. A flipped payload bit with correct check bits shows that the error comes from the computation and not only from the received field.

Runs with invalid cycles that carry garbage markers test the valid gating. Turning enable, format and alignment off and on shows that stale state is discarded and that the two-marker warm-up is kept. A read-and-clear that lands on a failing boundary, and a narrow second instance driven past its maximum, test the counter edges.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;

  // Strobes from the control into the datapath, one set per cycle.
  typedef struct packed {
    logic flush;     // checking inactive: discard all collected state
    logic advance;   // an accepted bit is present this cycle
    logic smfBound;  // accepted bit is the first of a submultiframe
    logic chkPos;    // accepted bit sits at a check-bit position
    logic compare;   // evaluate stored computed value against received bits
  } crcStrobe_t;

endpackage

// File: rtl/e1crc_ctrl.sv
module e1crc_ctrl
  import e1crc_pkg::*;
#(
  parameter int FRAMES_PER_SMF = 8,
  parameter int CHK_BITS       = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       crcFormat,
  input  logic       alignOk,
  input  logic       bitValid,
  input  logic       frameStart,
  input  logic       smfStart,
  output crcStrobe_t strb
);

  localparam int FRM_W    = $clog2(FRAMES_PER_SMF);
  localparam int CHK_SPAN = 2 * CHK_BITS;

  logic             active;
  logic             frameEdge;
  logic [FRM_W-1:0] frmCnt;
  logic [FRM_W-1:0] curFrame;
  logic             inSmf;     // a submultiframe is being collected from its start
  logic             havePrev;  // a computed value for the previous full SMF is held

  assign active    = enable & crcFormat & alignOk;
  assign frameEdge = smfStart | frameStart;

  // Index of the frame the current bit belongs to.
  always_comb begin
    curFrame = frmCnt;
    if (smfStart)        curFrame = '0;
    else if (frameStart) curFrame = frmCnt + 1'b1;
  end

  always_comb begin
    strb.flush    = ~active;
    strb.advance  = active & bitValid;
    strb.smfBound = strb.advance & smfStart;
    strb.chkPos   = strb.advance & frameEdge & ~curFrame[0]
                    & (int'(curFrame) < CHK_SPAN);
    strb.compare  = strb.smfBound & havePrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmCnt   <= '0;
      inSmf    <= 1'b0;
      havePrev <= 1'b0;
    end else if (!active) begin
      frmCnt   <= '0;
      inSmf    <= 1'b0;
      havePrev <= 1'b0;
    end else if (bitValid && frameEdge) begin
      frmCnt <= curFrame;
      if (smfStart) begin
        havePrev <= inSmf;
        inSmf    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/e1crc_datapath.sv
module e1crc_datapath
  import e1crc_pkg::*;
#(
  parameter int                  CHK_BITS = 4,
  parameter logic [CHK_BITS-1:0] POLY     = 4'b0011
) (
  input  logic       clk,
  input  logic       rstN,
  input  crcStrobe_t strb,
  input  logic       bitData,
  output logic       mismatch
);

  logic [CHK_BITS-1:0] crcReg;   // running remainder of the current SMF
  logic [CHK_BITS-1:0] rxChk;    // check bits gathered in the current SMF
  logic [CHK_BITS-1:0] prevCrc;  // final remainder of the previous SMF
  logic [CHK_BITS-1:0] crcBase;
  logic [CHK_BITS-1:0] crcNxt;
  logic                dEff;
  logic                fb;

  // Check positions enter the division as zero.
  assign dEff    = bitData & ~strb.chkPos;
  assign crcBase = strb.smfBound ? '0 : crcReg;
  assign fb      = crcBase[CHK_BITS-1] ^ dEff;
  assign crcNxt  = {crcBase[CHK_BITS-2:0], 1'b0} ^ (fb ? POLY : '0);

  assign mismatch = strb.compare & (prevCrc != rxChk);

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      crcReg  <= '0;
      rxChk   <= '0;
      prevCrc <= '0;
    end else if (strb.advance) begin
      crcReg <= crcNxt;
      if (strb.smfBound) begin
        prevCrc <= crcReg;
        rxChk   <= strb.chkPos ? {{(CHK_BITS-1){1'b0}}, bitData} : '0;
      end else if (strb.chkPos) begin
        rxChk <= {rxChk[CHK_BITS-2:0], bitData};
      end
    end
  end

endmodule

// File: rtl/e1crc_errcnt.sv
module e1crc_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mismatch,
  input  logic             rdClr,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] rdValue,
  output logic             errPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic atMax;
  assign atMax = (errCount == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCount <= '0;
      rdValue  <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= mismatch;
      if (rdClr) begin
        rdValue  <= errCount;
        errCount <= mismatch ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
      end else if (mismatch && !atMax) begin
        errCount <= errCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/e1_crc4_checker.sv
module e1_crc4_checker
  import e1crc_pkg::*;
#(
  parameter int                  CNT_W          = 16,
  parameter int                  FRAMES_PER_SMF = 8,
  parameter int                  CHK_BITS       = 4,
  parameter logic [CHK_BITS-1:0] POLY           = 4'b0011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             crcFormat,
  input  logic             alignOk,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic             frameStart,
  input  logic             smfStart,
  input  logic             rdClr,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] rdValue,
  output logic             errPulse
);

  crcStrobe_t strb;
  logic       mismatch;

  e1crc_ctrl #(
    .FRAMES_PER_SMF(FRAMES_PER_SMF),
    .CHK_BITS      (CHK_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .crcFormat (crcFormat),
    .alignOk   (alignOk),
    .bitValid  (bitValid),
    .frameStart(frameStart),
    .smfStart  (smfStart),
    .strb      (strb)
  );

  e1crc_datapath #(
    .CHK_BITS(CHK_BITS),
    .POLY    (POLY)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bitData (bitData),
    .mismatch(mismatch)
  );

  e1crc_errcnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rstN    (rstN),
    .mismatch(mismatch),
    .rdClr   (rdClr),
    .errCount(errCount),
    .rdValue (rdValue),
    .errPulse(errPulse)
  );

endmodule

// File: rtl/e1_crc4_checker_sva.sv
module e1_crc4_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             crcFormat,
  input logic             alignOk,
  input logic             bitValid,
  input logic             smfStart,
  input logic             rdClr,
  input logic [CNT_W-1:0] errCount,
  input logic [CNT_W-1:0] rdValue,
  input logic             errPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3: a pulse only follows an accepted submultiframe boundary
  a_r3_pulse_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(bitValid && smfStart));

  // R7: a pulse only follows a cycle with checking active
  a_r7_pulse_needs_active: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(enable && crcFormat && alignOk));

  // R7: inactive checking leaves the count alone
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!(enable && crcFormat && alignOk) && !rdClr) |=> ($stable(errCount) && !errPulse));

  // R9: an invalid cycle changes nothing
  a_r9_gap_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !rdClr) |=> ($stable(errCount) && !errPulse));

  // R4: without a clear the count moves by at most one
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !rdClr |=> ((errCount == $past(errCount)) || (errCount == $past(errCount) + 1'b1)));

  // R4: a pulse below the maximum comes with one added count
  a_r4_pulse_counts: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !$past(rdClr) && ($past(errCount) != CNT_MAX))
      |-> (errCount == $past(errCount) + 1'b1));

  // R5: the counter holds at its maximum
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rstN)
    ((errCount == CNT_MAX) && !rdClr) |=> (errCount == CNT_MAX));

  // R6: read-and-clear captures and restarts
  a_r6_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    rdClr |=> ((rdValue == $past(errCount)) && (errCount <= 1)));

endmodule

bind e1_crc4_checker e1_crc4_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .crcFormat(crcFormat),
  .alignOk  (alignOk),
  .bitValid (bitValid),
  .smfStart (smfStart),
  .rdClr    (rdClr),
  .errCount (errCount),
  .rdValue  (rdValue),
  .errPulse (errPulse)
);

// File: tb/e1_crc4_checker_tb.sv
`timescale 1ns/1ps
module e1_crc4_checker_tb;

  localparam int SMF_BITS   = 2048;
  localparam int FRAME_BITS = 256;
  localparam int SAT_MAX    = 3;

  logic        clk = 1'b0;
  logic        rstN, enable, crcFormat, alignOk;
  logic        bitValid, bitData, frameStart, smfStart, rdClr;
  logic [15:0] errCount, rdValue;
  logic        errPulse;
  logic [1:0]  satCount, satRd;
  logic        satPulse;
  logic        evtArm;

  always #10 clk = ~clk;

  e1_crc4_checker u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .crcFormat(crcFormat), .alignOk(alignOk),
    .bitValid(bitValid), .bitData(bitData), .frameStart(frameStart), .smfStart(smfStart),
    .rdClr(rdClr), .errCount(errCount), .rdValue(rdValue), .errPulse(errPulse));

  e1_crc4_checker #(.CNT_W(2)) u_dutSat (
    .clk(clk), .rstN(rstN), .enable(enable), .crcFormat(crcFormat), .alignOk(alignOk),
    .bitValid(bitValid), .bitData(bitData), .frameStart(frameStart), .smfStart(smfStart),
    .rdClr(rdClr), .errCount(satCount), .rdValue(satRd), .errPulse(satPulse));

  typedef struct { bit expErr; int expCnt; int expSat; } item_t;
  item_t sbq[$];

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per comparing boundary.
  always @(posedge clk) begin
    if (rstN && evtArm) begin
      #1;
      if (sbq.size() == 0) begin
        check(1'b0, "R3", "boundary with empty scoreboard", 0, 1);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(errPulse == it.expErr, "R3", "errPulse at compare", int'(errPulse), int'(it.expErr));
        check(int'(errCount) == it.expCnt, "R4", "errCount after compare", int'(errCount), it.expCnt);
        check(int'(satCount) == it.expSat, "R5", "narrow count after compare", int'(satCount), it.expSat);
      end
    end else if (rstN) begin
      #1;
      if (errPulse !== 1'b0 || satPulse !== 1'b0) begin
        nChecks++;
        nFails++;
        $display("FAIL R8 pulse without a comparing boundary act=%0d exp=0", int'(errPulse));
      end
    end
  end

  // Reference state
  logic       smfBits [SMF_BITS];
  logic [3:0] lastGood, crcM1, crcM2, chkM1;
  int         modelCnt, modelSat, smfIdx, expRd, expRdSat;
  bit         bActive;

  function automatic bit isChkPos(input int i);
    return ((i % FRAME_BITS) == 0) && (((i / FRAME_BITS) % 2) == 0);
  endfunction

  // Long division of the SMF (check positions as zero), then four zero bits.
  function automatic logic [3:0] crcRef();
    logic [3:0] r = 4'b0;
    for (int i = 0; i < SMF_BITS + 4; i++) begin
      logic d, top;
      d   = (i < SMF_BITS) ? (isChkPos(i) ? 1'b0 : smfBits[i]) : 1'b0;
      top = r[3];
      r   = {r[2:0], d};
      if (top) r = r ^ 4'b0011;
    end
    return r;
  endfunction

  task automatic setActive(input logic en, input logic fmt, input logic al);
    @(negedge clk);
    enable = en; crcFormat = fmt; alignOk = al;
    bActive = en && fmt && al;
    if (!bActive) smfIdx = 0;
  endtask

  task automatic sendSmf(input logic [3:0] chk, input bit flip, input bit clrAtStart,
                         input bit gaps);
    logic [3:0] act;
    bit expectCmp, expErr;
    for (int i = 0; i < SMF_BITS; i++)
      smfBits[i] = isChkPos(i) ? chk[3 - (i / FRAME_BITS) / 2] : (($urandom & 1) != 0);
    lastGood = crcRef();
    if (flip) smfBits[777] = ~smfBits[777];
    act = crcRef();
    expectCmp = bActive && (smfIdx >= 2);
    expErr    = expectCmp && (crcM2 != chkM1);
    if (clrAtStart) begin
      expRd = modelCnt; expRdSat = modelSat;
      modelCnt = expErr ? 1 : 0;
      modelSat = expErr ? 1 : 0;
    end else if (expErr) begin
      if (modelCnt < 65535) modelCnt++;
      if (modelSat < SAT_MAX) modelSat++;
    end
    if (expectCmp) sbq.push_back('{expErr, modelCnt, modelSat});
    crcM2 = crcM1; crcM1 = act; chkM1 = chk;
    if (bActive) smfIdx++;
    for (int i = 0; i < SMF_BITS; i++) begin
      @(negedge clk);
      if (gaps && (i % 97) == 5) begin
        bitValid = 1'b0; smfStart = 1'b1; frameStart = 1'b1;
        bitData = (($urandom & 1) != 0); evtArm = 1'b0; rdClr = 1'b0;
        @(negedge clk);
      end
      bitValid   = 1'b1;
      bitData    = smfBits[i];
      frameStart = (i % FRAME_BITS) == 0;
      smfStart   = (i == 0);
      evtArm     = (i == 0) && expectCmp;
      rdClr      = (i == 0) && clrAtStart;
    end
    @(negedge clk);
    bitValid = 1'b0; smfStart = 1'b0; frameStart = 1'b0;
    evtArm = 1'b0; rdClr = 1'b0;
  endtask

  task automatic doRead();
    int e, es;
    @(negedge clk);
    rdClr = 1'b1;
    e = modelCnt; es = modelSat;
    modelCnt = 0; modelSat = 0;
    @(negedge clk);
    rdClr = 1'b0;
    check(int'(rdValue) == e, "R6", "rdValue after idle read", int'(rdValue), e);
    check(int'(satRd) == es, "R6", "narrow rdValue after idle read", int'(satRd), es);
    check(errCount == 16'd0, "R6", "errCount cleared", int'(errCount), 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; crcFormat = 1'b0; alignOk = 1'b0;
    bitValid = 1'b0; bitData = 1'b0; frameStart = 1'b0; smfStart = 1'b0;
    rdClr = 1'b0; evtArm = 1'b0;
    modelCnt = 0; modelSat = 0; smfIdx = 0; bActive = 0;
    crcM1 = '0; crcM2 = '0; chkM1 = '0; lastGood = '0; expRd = 0; expRdSat = 0;
    repeat (4) @(negedge clk);
    check(errCount == 16'd0, "R10", "errCount in reset", int'(errCount), 0);
    check(rdValue == 16'd0, "R10", "rdValue in reset", int'(rdValue), 0);
    check(errPulse == 1'b0, "R10", "errPulse in reset", int'(errPulse), 0);
    rstN = 1'b1;

    // Clean stream; R1 and R2 through matching comparisons; R9 via gaps
    setActive(1, 1, 1);
    sendSmf(4'hA, 0, 0, 0);
    sendSmf(lastGood, 0, 0, 1);
    sendSmf(lastGood, 0, 0, 0);
    sendSmf(lastGood, 0, 0, 1);
    check(errCount == 16'd0, "R9", "clean stream with invalid gaps", int'(errCount), 0);
    // One wrong check bit (R2), all four wrong (R4), payload flip (R1)
    sendSmf(lastGood ^ 4'b0100, 0, 0, 0);
    sendSmf(~lastGood, 0, 0, 0);
    sendSmf(lastGood, 1, 0, 0);
    sendSmf(lastGood, 0, 0, 0);
    sendSmf(lastGood, 0, 0, 0);
    check(int'(errCount) == modelCnt, "R1", "count after bit and payload errors", int'(errCount), modelCnt);
    // Read-and-clear on a failing boundary (R6)
    sendSmf(lastGood ^ 4'b0001, 0, 0, 0);
    sendSmf(lastGood, 0, 1, 0);
    check(int'(rdValue) == expRd, "R6", "rdValue captured on failing boundary", int'(rdValue), expRd);
    check(int'(satRd) == expRdSat, "R6", "narrow rdValue on failing boundary", int'(satRd), expRdSat);
    check(errCount == 16'd1, "R6", "error in clear cycle kept", int'(errCount), 1);
    doRead();

    // Disabled: bad check bits are not counted (R7)
    setActive(0, 1, 1);
    sendSmf(lastGood ^ 4'b0011, 0, 0, 0);
    sendSmf(lastGood ^ 4'b1000, 0, 0, 0);
    check(int'(errCount) == modelCnt, "R7", "disabled stream not counted", int'(errCount), modelCnt);
    // Re-enable: two warm-up boundaries, then compare (R8)
    setActive(1, 1, 1);
    sendSmf(lastGood ^ 4'b0101, 0, 0, 0);
    sendSmf(lastGood ^ 4'b0110, 0, 0, 0);
    check(int'(errCount) == modelCnt, "R8", "no compare during warm-up", int'(errCount), modelCnt);
    sendSmf(lastGood, 0, 0, 0);
    check(int'(errCount) == modelCnt, "R8", "first compare at third boundary", int'(errCount), modelCnt);
    // Format off, then alignment lost (R7)
    setActive(1, 0, 1);
    sendSmf(lastGood ^ 4'b1111, 0, 0, 0);
    sendSmf(lastGood ^ 4'b1111, 0, 0, 0);
    setActive(1, 1, 0);
    sendSmf(lastGood ^ 4'b1111, 0, 0, 0);
    sendSmf(lastGood ^ 4'b1111, 0, 0, 0);
    check(int'(errCount) == modelCnt, "R7", "format off and alignment lost", int'(errCount), modelCnt);

    // Drive the narrow counter past its maximum (R5)
    setActive(1, 1, 1);
    for (int k = 0; k < 6; k++) sendSmf(lastGood ^ 4'b0010, 0, 0, 0);
    sendSmf(lastGood, 0, 0, 0);
    check(int'(satCount) == SAT_MAX, "R5", "narrow counter held at maximum", int'(satCount), SAT_MAX);
    check(int'(errCount) == modelCnt, "R5", "wide counter keeps counting", int'(errCount), modelCnt);
    check(sbq.size() == 0, "R3", "all comparisons observed", sbq.size(), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule